// File: doc/BRIEF.md
# SPI EEPROM Boot Loader

This block is the power-up program loader for a small processor subsystem. Once reset is released it acts as an SPI master toward a serial EEPROM: it drives the chip select low, sends a read opcode and an all-zero address, and reads back a four-byte ASCII marker. A marker that differs means the SPI settings do not suit the attached device. The loader then deselects the device, moves on to the next of three fixed settings, and reads from address zero again. If none of the three settings returns the marker, the loader stops for good and raises a halt flag.

Once the marker is read, the byte stream carries a two-word header: the word count first, then the load address. Program words follow. Every word comes in as two bytes with the low byte first. The words go out on a program RAM write port at consecutive addresses. When the last word has been written, the select pin is released back to its reset function, as an input under peripheral control, so the output enable drops. The loader presents the load address as the jump target and pulses `done` for one cycle. The program-RAM disable output is held low the whole time.

Top module: `spi_boot_loader`

## Requirements
- R1: In the first cycle after synchronous reset is released, `sel_n` and `sel_oe` are 1, and `done`, `halted` and `prog_we` are 0.
- R2: Every attempt drives `sel_n` low, then sends the read opcode 0x03 followed by zero address bytes on `spi_mosi`, most significant bit first. It sends two address bytes under settings 1 and 2 and three under setting 3. One SCK period lasts `CLK_DIV` system clocks.
- R3: The settings are tried in a fixed order. Setting 1 is SPI mode 0 with a 16-bit address, setting 2 is mode 3 with a 16-bit address, and setting 3 is mode 0 with a 24-bit address. SCK rests low in mode 0 and high in mode 3. Between two attempts `sel_n` stays high for at least 2*`CLK_DIV` clocks.
- R4: An attempt is accepted only when the four bytes after the address are 0x42, 0x4F, 0x4F, 0x54, in that order. Any other byte ends the attempt.
- R5: If the third setting also fails, `halted` is set and stays set. After that there are no RAM writes and no `done`, and `sel_n` stays high.
- R6: After the marker come two header words, each made of two bytes with the low byte first. The first word is the word count N and the second is the load address S.
- R7: Program word k (k = 0..N-1) is assembled with its low byte first and written with one `prog_we` pulse to `prog_addr` = S+k. The writes come in increasing k.
- R8: `done` is high for exactly one cycle. In that cycle `jump_addr` = S, `sel_n` = 1 and `sel_oe` = 0. If N > 0, the write of the last word falls in that same cycle. `sel_oe` stays 0 afterwards.
- R9: With N = 0 the loader writes nothing and still produces `done` with `jump_addr` = S.
- R10: `pram_off` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_sck | output | 1 | Serial clock toward the EEPROM |
| spi_mosi | output | 1 | Serial data toward the EEPROM |
| sel_n | output | 1 | Chip select level driven on the shared pin (active low) |
| sel_oe | output | 1 | Output enable of the shared select pin; 0 returns the pin to input |
| prog_we | output | 1 | Program RAM write strobe |
| prog_addr | output | 16 | Program RAM write address |
| prog_wdata | output | 16 | Program RAM write data |
| done | output | 1 | One-cycle pulse when loading is complete |
| jump_addr | output | 16 | Start address taken from the header |
| halted | output | 1 | Permanent halt after all settings failed |
| pram_off | output | 1 | Program RAM disable, held at 0 |

## Verification
The write of the last program word, the release of the select pin and the `done` pulse all land in the same cycle. So a mistake there would show up as a dropped final write or a write made after the pin has been released. The bench runs programs of random length and random content at random load addresses, including a one-word program. At each `done` it records `prog_we`, `sel_n` and `sel_oe`, and it compares the full write list with the image it built. The halt path is checked as well: the bench uses an EEPROM model set to a mode and address width that no setting matches, and a device whose marker has one wrong byte. It confirms that the halt neither writes nor signals completion.

// File: rtl/spiboot_pkg.sv
package spiboot_pkg;

    typedef enum logic [2:0] {
        ST_GAP, ST_CMD, ST_SIG, ST_HDR, ST_LOAD, ST_FIN, ST_PARK, ST_HALT
    } boot_state_t;

    typedef struct packed {
        logic       cpol_hi;     // SCK rests high (mode 3) when set
        logic [1:0] addr_bytes;  // address bytes after the opcode
    } spi_cfg_t;

    localparam int         NUM_CFG = 3;
    localparam logic [7:0] READ_OP = 8'h03;

    function automatic spi_cfg_t cfg_of(input logic [1:0] idx);
        spi_cfg_t c;
        c.cpol_hi    = (idx == 2'd1);
        c.addr_bytes = (idx == 2'd2) ? 2'd3 : 2'd2;
        return c;
    endfunction

    function automatic logic [7:0] marker_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'h42;
            2'd1:    return 8'h4F;
            2'd2:    return 8'h4F;
            default: return 8'h54;
        endcase
    endfunction

endpackage

// File: rtl/spib_byte_engine.sv
module spib_byte_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       cpol_hi,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active, half, done_q;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh, rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            half   <= 1'b0;
            done_q <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    half   <= 1'b0;
                    cnt    <= '0;
                    bitn   <= '0;
                    tx_sh  <= tx_byte;
                end
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                if (!half) begin
                    half  <= 1'b1;                    // rising edge: sample
                    rx_sh <= {rx_sh[6:0], miso};
                end else if (bitn == 3'd7) begin
                    active <= 1'b0;
                    half   <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    half  <= 1'b0;                    // falling edge: next bit
                    bitn  <= bitn + 3'd1;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign sck       = active ? half : cpol_hi;
    assign mosi      = active ? tx_sh[7] : 1'b0;
    assign busy      = active;
    assign byte_done = done_q;
    assign rx_byte   = rx_sh;
endmodule

// File: rtl/spib_word_packer.sv
module spib_word_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int BPW = WORD_W / 8;
    localparam int PW  = (BPW > 1) ? $clog2(BPW) : 1;

    logic [PW-1:0]     pos;
    logic [WORD_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos <= '0;
            acc <= '0;
        end else if (byte_valid) begin
            acc <= {byte_in, acc[WORD_W-1:8]};
            pos <= (pos == PW'(BPW - 1)) ? '0 : pos + PW'(1);
        end
    end

    assign word_valid = byte_valid && (pos == PW'(BPW - 1));
    assign word       = {byte_in, acc[WORD_W-1:8]};
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
    import spiboot_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_miso,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              sel_n,
    output logic              sel_oe,
    output logic              prog_we,
    output logic [WORD_W-1:0] prog_addr,
    output logic [WORD_W-1:0] prog_wdata,
    output logic              done,
    output logic [WORD_W-1:0] jump_addr,
    output logic              halted,
    output logic              pram_off
);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    boot_state_t       state;
    logic [1:0]        cfg_idx;
    logic [2:0]        byte_idx;
    logic [GW-1:0]     gap_cnt;
    logic [WORD_W-1:0] words_left, wr_addr, jump_q;
    logic              we_q;
    logic [WORD_W-1:0] waddr_q, wdata_q;

    spi_cfg_t          cfg;
    logic              need_byte, eng_busy, eng_done, eng_start, word_valid;
    logic [7:0]        tx, rx;
    logic [WORD_W-1:0] word;

    assign cfg       = cfg_of(cfg_idx);
    assign need_byte = (state == ST_CMD) || (state == ST_SIG) ||
                       (state == ST_HDR) || (state == ST_LOAD);
    assign eng_start = need_byte && !eng_busy && !eng_done;
    assign tx        = (state == ST_CMD && byte_idx == 3'd0) ? READ_OP : 8'h00;

    spib_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst), .start(eng_start), .tx_byte(tx),
        .cpol_hi(cfg.cpol_hi), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .busy(eng_busy), .byte_done(eng_done), .rx_byte(rx)
    );

    spib_word_packer #(.WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst(rst), .clr(state == ST_SIG),
        .byte_valid(eng_done && (state == ST_HDR || state == ST_LOAD)),
        .byte_in(rx), .word_valid(word_valid), .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_GAP;
            cfg_idx    <= '0;
            byte_idx   <= '0;
            gap_cnt    <= '0;
            words_left <= '0;
            wr_addr    <= '0;
            jump_q     <= '0;
            we_q       <= 1'b0;
            waddr_q    <= '0;
            wdata_q    <= '0;
        end else begin
            we_q <= 1'b0;
            unique case (state)
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CYC - 1)) begin
                        gap_cnt  <= '0;
                        byte_idx <= '0;
                        state    <= ST_CMD;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                ST_CMD: if (eng_done) begin
                    if (byte_idx == 3'(cfg.addr_bytes)) begin
                        byte_idx <= '0;
                        state    <= ST_SIG;
                    end else begin
                        byte_idx <= byte_idx + 3'd1;
                    end
                end
                ST_SIG: if (eng_done) begin
                    if (rx != marker_byte(byte_idx[1:0])) begin
                        if (cfg_idx == 2'(NUM_CFG - 1)) begin
                            state <= ST_HALT;
                        end else begin
                            cfg_idx <= cfg_idx + 2'd1;
                            state   <= ST_GAP;
                        end
                    end else if (byte_idx == 3'd3) begin
                        byte_idx <= '0;
                        state    <= ST_HDR;
                    end else begin
                        byte_idx <= byte_idx + 3'd1;
                    end
                end
                ST_HDR: if (word_valid) begin
                    if (byte_idx == 3'd0) begin
                        words_left <= word;
                        byte_idx   <= 3'd1;
                    end else begin
                        wr_addr <= word;
                        jump_q  <= word;
                        state   <= (words_left == '0) ? ST_FIN : ST_LOAD;
                    end
                end
                ST_LOAD: if (word_valid) begin
                    we_q       <= 1'b1;
                    waddr_q    <= wr_addr;
                    wdata_q    <= word;
                    wr_addr    <= wr_addr + WORD_W'(1);
                    words_left <= words_left - WORD_W'(1);
                    if (words_left == WORD_W'(1)) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_PARK;
                default: state <= state;   // ST_PARK, ST_HALT hold
            endcase
        end
    end

    assign sel_n      = !need_byte;
    assign sel_oe     = !(state == ST_FIN || state == ST_PARK);
    assign prog_we    = we_q;
    assign prog_addr  = waddr_q;
    assign prog_wdata = wdata_q;
    assign done       = (state == ST_FIN);
    assign jump_addr  = jump_q;
    assign halted     = (state == ST_HALT);
    assign pram_off   = 1'b0;
endmodule

// File: rtl/spib_checks.sv
module spib_checks (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic sel_oe,
    input logic prog_we,
    input logic done,
    input logic halted
);
    // R1: state right after reset release
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_n && sel_oe && !done && !halted && !prog_we));

    // R8: completion pulse lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: pin released while done is high
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_n && !sel_oe));

    // R8: released pin stays released and no write follows
    p_release_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !sel_oe |=> (!sel_oe && !prog_we && !done));

    // R5: halt is permanent
    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R5: halt is quiet
    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!prog_we && !done && sel_n && sel_oe));
endmodule

bind spi_boot_loader spib_checks u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_oe(sel_oe),
    .prog_we(prog_we), .done(done), .halted(halted)
);

// File: tb/spi_boot_loader_tb.sv
module spi_boot_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;

    logic clk = 1'b0, rst = 1'b1, spi_miso;
    logic spi_sck, spi_mosi, sel_n, sel_oe, prog_we, done, halted, pram_off;
    logic [15:0] prog_addr, prog_wdata, jump_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_boot_loader #(.CLK_DIV(CLK_DIV), .WORD_W(16)) u_dut (
        .clk(clk), .rst(rst), .spi_miso(spi_miso), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .sel_n(sel_n), .sel_oe(sel_oe), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata), .done(done),
        .jump_addr(jump_addr), .halted(halted), .pram_off(pram_off)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [7:0] mem [256];
    bit  dev_m3 = 0;
    int  dev_ab = 2;
    int  fall_cnt = 0, bitn = 0;
    logic miso_r = 1'b0;
    logic [31:0] cmd_cap = '0, cmd_seen = '0;
    wire ss_line = sel_oe ? sel_n : 1'b1;
    assign spi_miso = miso_r;

    function automatic logic stream_bit(input int p);
        int b, d;
        if (p < 0) return 1'b0;
        b = p / 8;
        if (b < 1 + dev_ab) return 1'b0;
        d = b - 1 - dev_ab;
        if (d > 255) return 1'b0;
        return mem[d][7 - (p % 8)];
    endfunction

    always @(negedge spi_sck or posedge ss_line) begin
        if (ss_line) begin
            fall_cnt = 0;
            miso_r   = 1'b0;
        end else begin
            fall_cnt++;
            miso_r = stream_bit(fall_cnt - (dev_m3 ? 1 : 0));
        end
    end

    always @(posedge spi_sck or posedge ss_line) begin
        if (ss_line) begin
            if (bitn >= 32) cmd_seen = cmd_cap;
            bitn = 0;
        end else if (bitn < 32) begin
            cmd_cap = {cmd_cap[30:0], spi_mosi};
            bitn++;
        end
    end

    // ---------------- port monitor (off-edge) ----------------
    logic [15:0] wa [64], wd [64];
    int wn, done_cnt, attempts, min_gap, hi_run, rise_n, r0, r1, cyc;
    logic done_jump_ok_dummy;
    logic [15:0] done_jump;
    logic done_ss, done_oe, done_we;
    logic sel_sck [4];
    logic prev_ss, prev_sck;

    always @(negedge clk) begin
        if (rst) begin
            wn = 0; done_cnt = 0; attempts = 0; min_gap = 1000000; hi_run = 0;
            rise_n = 0; r0 = 0; r1 = 0; cyc = 0; prev_ss = 1'b1; prev_sck = spi_sck;
            done_ss = 0; done_oe = 1; done_we = 0; done_jump = '0;
        end else begin
            if (prog_we) begin
                if (wn < 64) begin wa[wn] = prog_addr; wd[wn] = prog_wdata; end
                wn++;
            end
            if (done) begin
                done_cnt++; done_jump = jump_addr; done_ss = sel_n;
                done_oe = sel_oe; done_we = prog_we;
            end
            if (prev_ss && !ss_line) begin
                if (attempts < 4) sel_sck[attempts] = spi_sck;
                if (attempts > 0 && hi_run < min_gap) min_gap = hi_run;
                attempts++;
                rise_n = 0;
            end
            hi_run = ss_line ? hi_run + 1 : 0;
            if (!ss_line && spi_sck && !prev_sck) begin
                if (rise_n == 0) r0 = cyc;
                else if (rise_n == 1) r1 = cyc;
                rise_n++;
            end
            prev_ss = ss_line; prev_sck = spi_sck; cyc++;
        end
    end

    // ---------------- scenario ----------------
    task automatic run_case(input bit m3, input int ab, input bit bad_sig,
                            input int nw, input int exp_att, input bit exp_halt);
        logic [15:0] start;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'h42; mem[1] = 8'h4F; mem[2] = 8'h4F; mem[3] = bad_sig ? 8'h55 : 8'h54;
        start  = 16'($urandom) & 16'hFFC0;
        mem[4] = nw[7:0]; mem[5] = nw[15:8]; mem[6] = start[7:0]; mem[7] = start[15:8];
        for (int i = 0; i < 2 * nw; i++) mem[8 + i] = 8'($urandom);
        dev_m3 = m3; dev_ab = ab;

        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(sel_n && sel_oe && !done && !halted && !prog_we, "R1", "reset outputs",
            {sel_n, sel_oe, done, halted, prog_we}, 5'b11000);
        chk(pram_off == 1'b0, "R10", "pram_off after reset", pram_off, 0);

        for (int i = 0; i < 30000 && done_cnt == 0 && !halted; i++) @(negedge clk);
        repeat (300) @(negedge clk);

        chk(attempts == exp_att, "R3", "attempt count", attempts, exp_att);
        for (int i = 0; i < exp_att && i < 4; i++)
            chk(sel_sck[i] == (i == 1), "R3", "sck rest level at select", sel_sck[i], (i == 1));
        if (exp_att > 1)
            chk(min_gap >= 2 * CLK_DIV, "R3", "deselect gap", min_gap, 2 * CLK_DIV);
        chk(r1 - r0 == CLK_DIV, "R2", "sck period", r1 - r0, CLK_DIV);
        chk(cmd_seen == 32'h0300_0000, "R2", "opcode and address", cmd_seen, 32'h0300_0000);
        chk(pram_off == 1'b0, "R10", "pram_off at end", pram_off, 0);

        if (exp_halt) begin
            chk(halted == 1'b1, bad_sig ? "R4" : "R5", "halted", halted, 1);
            chk(wn == 0 && done_cnt == 0, "R5", "writes+done during halt", wn + done_cnt, 0);
            chk(ss_line == 1'b1, "R5", "select high in halt", ss_line, 1);
        end else begin
            chk(halted == 1'b0, "R4", "not halted", halted, 0);
            chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
            chk(done_jump == start, "R8", "jump address", done_jump, start);
            chk(done_ss && !done_oe, "R8", "select released at done",
                {done_ss, done_oe}, 2'b10);
            if (nw > 0)
                chk(done_we == 1'b1, "R8", "last write with done", done_we, 1);
            chk(wn == nw, nw == 0 ? "R9" : "R7", "write count", wn, nw);
            for (int k = 0; k < nw && k < 64; k++) begin
                chk(wa[k] == start + 16'(k), "R7", "write address", wa[k], start + 16'(k));
                chk(wd[k] == {mem[9 + 2 * k], mem[8 + 2 * k]}, "R6", "write data",
                    wd[k], {mem[9 + 2 * k], mem[8 + 2 * k]});
            end
            chk(ss_line == 1'b1 && sel_oe == 1'b0, "R8", "pin stays released",
                {ss_line, sel_oe}, 2'b10);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        run_case(1'b0, 2, 1'b0, 5, 1, 1'b0);                       // setting 1 matches
        run_case(1'b1, 2, 1'b0, 1 + int'($urandom % 8), 2, 1'b0);  // setting 2 matches
        run_case(1'b0, 3, 1'b0, 1 + int'($urandom % 8), 3, 1'b0);  // setting 3 matches
        run_case(1'b0, 2, 1'b0, 0, 1, 1'b0);                       // R9 empty program
        run_case(1'b0, 2, 1'b0, 1, 1, 1'b0);                       // single word
        run_case(1'b1, 3, 1'b0, 4, 3, 1'b1);                       // R5 nothing matches
        run_case(1'b0, 2, 1'b1, 4, 3, 1'b1);                       // R4 wrong last marker byte
        for (int r = 0; r < 3; r++)
            run_case(1'b0, 2, 1'b0, 2 + int'($urandom % 20), 1, 1'b0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule